// File: doc/BRIEF.md
# Scan-Test Clock Controller

This block sits in front of one clock domain and decides, mode by mode, which clock reaches the domain's flops during scan test. It receives a fast functional clock, a slow shift clock and an optional test-access-port clock. Two latch-based gated-clock cells and a final clock multiplexer produce a single output clock. In mission operation the fast clock passes straight through. During scan shift the slow clock drives the chains. During capture, a small condition register that sits on the scan chain sets how many capture pulses are released, on the fast clock or on the slow clock.

The condition register is loaded through the scan chain together with the rest of the design. During capture it keeps shifting on the same clock that does the capture. Each released pulse moves the register one place, and pulses stop when a zero reaches its output bit. Several controls change this behaviour. A kill input blocks the fast clock in mission operation. A shift-only setting routes the slow clock while the controller is otherwise idle. The access-port clock can be injected onto the slow path. An upstream-parent flag lets fast capture start without waiting for the scan-enable synchronizer. A parent variant (parameter) keeps the clock selection but leaves pulse chopping to a downstream controller.

Top module: `scanClockCtl`

## Requirements
- R1: With testMode low, killClockEn low, injectTck low and not (shiftOnlyMode and scanEn), clkOut follows fastClk edge for edge.
- R2: With testMode low and killClockEn high (no injection, no shift-only shift), clkOut stays low. With testMode high, killClockEn has no effect on the number of capture pulses.
- R3: With testMode high and scanEn high, clkOut follows slowClk. The condition register enters condScanIn at its top bit, moves one place toward bit 0 on each rising clkOut, drives condScanOut from bit 0, and resets to all zeros.
- R4: Fast capture (testMode high, fastCaptureMode high, scanEn low): clkOut gives one fastClk pulse per consecutive one counted from bit 0 of the loaded condition register (condScanIn held low), then stays low.
- R5: Slow capture (testMode high, fastCaptureMode low, scanEn low): the same pulse count as R4, on slowClk, then clkOut stays low.
- R6: scanEn passes through a two-flop synchronizer on fastClk. Without upstreamParentActive, no fast capture pulse appears on the first two fastClk rising edges after scanEn falls. With it, pulses start on the first edge.
- R7: While injectTck is high, clkOut follows tckClk.
- R8: With testMode low, shiftOnlyMode high and scanEn high, clkOut follows slowClk.
- R9: With PARENT_MODE set, both gaters stay open apart from the R2 kill. In fast capture clkOut follows fastClk continuously, and in slow capture it follows slowClk, whatever the condition register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fastClk | input | 1 | Fast functional clock |
| slowClk | input | 1 | Slow shift clock |
| tckClk | input | 1 | Test-access-port clock for injection |
| rstN | input | 1 | Active-low asynchronous reset |
| testMode | input | 1 | Controller active |
| scanEn | input | 1 | Scan shift enable |
| fastCaptureMode | input | 1 | 1: capture on fast clock, 0: on slow clock |
| shiftOnlyMode | input | 1 | Slow-path shift while controller idle |
| killClockEn | input | 1 | Block fast clock when testMode is low |
| injectTck | input | 1 | Replace slow source by tckClk and select it |
| upstreamParentActive | input | 1 | Skip synchronizer wait in fast capture |
| condScanIn | input | 1 | Scan input of condition register |
| condScanOut | output | 1 | Scan output of condition register (bit 0) |
| clkOut | output | 1 | Controlled clock to the domain |

## Verification
The assertions assume that mode inputs are static relative to the fast clock's sampling edge and change only between edges. The mode equations are therefore checked on settled values. The synchronizer check assumes scanEn is driven from reset onward. The stimulus changes every control half a time unit after a slow-clock falling edge, when the slow clock is low and the fast clock is low, so that no switch lands on a clock edge. It lets each static mode settle before any counting window opens.

// File: rtl/sccPkg.sv
`timescale 1ns/1ps
package sccPkg;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_GATES = 2;
  localparam int GATE_FAST = 0;
  localparam int GATE_SLOW = 1;

  typedef struct packed {
    logic fastEn;
    logic slowEn;
    logic selSlow;
  } clkStrobesT;
endpackage

// File: rtl/sccClkGate.sv
`timescale 1ns/1ps
module sccClkGate (
  input  logic clkIn,
  input  logic enable,
  output logic clkGated
);
  logic enLatched;

  // transparent while the clock is low, so the enable can only change between pulses
  always_latch begin
    if (!clkIn) enLatched <= enable;
  end

  assign clkGated = clkIn & enLatched;
endmodule

// File: rtl/sccCtrl.sv
`timescale 1ns/1ps
module sccCtrl
  import sccPkg::*;
#(
  parameter bit PARENT_MODE = 1'b0
) (
  input  logic       fastClk,
  input  logic       rstN,
  input  logic       testMode,
  input  logic       scanEn,
  input  logic       fastCaptureMode,
  input  logic       shiftOnlyMode,
  input  logic       killClockEn,
  input  logic       injectTck,
  input  logic       upstreamParentActive,
  input  logic       condBit,
  output clkStrobesT strobes
);
  logic killGated;
  logic shiftOnlyShift;
  logic fastCaptureGo;
  logic syncNotScanEn;
  logic [SYNC_STAGES-1:0] notScanEnPipe;

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) notScanEnPipe <= '0;
    else       notScanEnPipe <= {notScanEnPipe[SYNC_STAGES-2:0], ~scanEn};
  end
  assign syncNotScanEn = notScanEnPipe[SYNC_STAGES-1];

  assign killGated      = killClockEn & ~testMode;
  assign shiftOnlyShift = shiftOnlyMode & scanEn;
  assign fastCaptureGo  = condBit & fastCaptureMode & (syncNotScanEn | upstreamParentActive);

  assign strobes.selSlow = ((scanEn | ~fastCaptureMode) & testMode) | injectTck | shiftOnlyShift;

  generate
    if (PARENT_MODE) begin : gParent
      assign strobes.fastEn = ~killGated;
      assign strobes.slowEn = 1'b1;
    end else begin : gChop
      assign strobes.fastEn = (fastCaptureGo | ~testMode) & ~killGated;
      assign strobes.slowEn = (((condBit & ~fastCaptureMode) | scanEn) & testMode)
                              | injectTck | shiftOnlyShift;

      AST_SYNC_HOLDS_OFF: assert property (@(posedge fastClk) disable iff (!rstN)
        $past(scanEn, 2) |-> !syncNotScanEn); // R6
    end
  endgenerate

  AST_FUNC_FAST_PATH: assert property (@(posedge fastClk) disable iff (!rstN)
    (!testMode && !killClockEn && !injectTck && !(shiftOnlyMode && scanEn))
      |-> (!strobes.selSlow && strobes.fastEn)); // R1
  AST_KILL_BLOCKS_FAST: assert property (@(posedge fastClk) disable iff (!rstN)
    (!testMode && killClockEn) |-> !strobes.fastEn); // R2
  AST_SHIFT_ON_SLOW: assert property (@(posedge fastClk) disable iff (!rstN)
    (testMode && scanEn) |-> (strobes.selSlow && strobes.slowEn)); // R3
  AST_TCK_ON_SLOW: assert property (@(posedge fastClk) disable iff (!rstN)
    injectTck |-> (strobes.selSlow && strobes.slowEn)); // R7
  AST_SHIFT_ONLY_SLOW: assert property (@(posedge fastClk) disable iff (!rstN)
    (!testMode && shiftOnlyMode && scanEn) |-> (strobes.selSlow && strobes.slowEn)); // R8
endmodule

// File: rtl/sccDatapath.sv
`timescale 1ns/1ps
module sccDatapath
  import sccPkg::*;
#(
  parameter int COND_LEN = 4
) (
  input  logic       fastClk,
  input  logic       slowClk,
  input  logic       tckClk,
  input  logic       rstN,
  input  logic       injectTck,
  input  logic       condScanIn,
  input  clkStrobesT strobes,
  output logic       condScanOut,
  output logic       clkOut
);
  logic                 slowSrc;
  logic [NUM_GATES-1:0] gateSrc;
  logic [NUM_GATES-1:0] gateEn;
  logic [NUM_GATES-1:0] gateOut;
  logic [COND_LEN-1:0]  condReg;

  assign slowSrc = injectTck ? tckClk : slowClk;

  assign gateSrc[GATE_FAST] = fastClk;
  assign gateSrc[GATE_SLOW] = slowSrc;
  assign gateEn[GATE_FAST]  = strobes.fastEn;
  assign gateEn[GATE_SLOW]  = strobes.slowEn;

  for (genvar g = 0; g < NUM_GATES; g++) begin : gGate
    sccClkGate uGate (
      .clkIn   (gateSrc[g]),
      .enable  (gateEn[g]),
      .clkGated(gateOut[g])
    );
  end

  assign clkOut = strobes.selSlow ? gateOut[GATE_SLOW] : gateOut[GATE_FAST];

  // condition register shifts on whatever clock the domain receives
  generate
    if (COND_LEN == 1) begin : gOne
      always_ff @(posedge clkOut or negedge rstN) begin
        if (!rstN) condReg <= '0;
        else       condReg <= condScanIn;
      end
    end else begin : gMany
      always_ff @(posedge clkOut or negedge rstN) begin
        if (!rstN) condReg <= '0;
        else       condReg <= {condScanIn, condReg[COND_LEN-1:1]};
      end
    end
  endgenerate

  assign condScanOut = condReg[0];
endmodule

// File: rtl/scanClockCtl.sv
`timescale 1ns/1ps
module scanClockCtl
  import sccPkg::*;
#(
  parameter int COND_LEN    = 4,
  parameter bit PARENT_MODE = 1'b0
) (
  input  logic fastClk,
  input  logic slowClk,
  input  logic tckClk,
  input  logic rstN,
  input  logic testMode,
  input  logic scanEn,
  input  logic fastCaptureMode,
  input  logic shiftOnlyMode,
  input  logic killClockEn,
  input  logic injectTck,
  input  logic upstreamParentActive,
  input  logic condScanIn,
  output logic condScanOut,
  output logic clkOut
);
  clkStrobesT strobes;
  logic       condBit;

  sccCtrl #(.PARENT_MODE(PARENT_MODE)) uCtrl (
    .fastClk             (fastClk),
    .rstN                (rstN),
    .testMode            (testMode),
    .scanEn              (scanEn),
    .fastCaptureMode     (fastCaptureMode),
    .shiftOnlyMode       (shiftOnlyMode),
    .killClockEn         (killClockEn),
    .injectTck           (injectTck),
    .upstreamParentActive(upstreamParentActive),
    .condBit             (condBit),
    .strobes             (strobes)
  );

  sccDatapath #(.COND_LEN(COND_LEN)) uPath (
    .fastClk    (fastClk),
    .slowClk    (slowClk),
    .tckClk     (tckClk),
    .rstN       (rstN),
    .injectTck  (injectTck),
    .condScanIn (condScanIn),
    .strobes    (strobes),
    .condScanOut(condBit),
    .clkOut     (clkOut)
  );

  assign condScanOut = condBit;
endmodule

// File: tb/sim_scanClockCtl.sv
`timescale 1ns/1ps
module sim_scanClockCtl;
  localparam int COND_LEN = 4;

  logic fastClk = 1'b0, slowClk = 1'b0, tckClk = 1'b0, rstN = 1'b0;
  logic testMode = 1'b0, scanEn = 1'b0, fastCaptureMode = 1'b0, shiftOnlyMode = 1'b0;
  logic killClockEn = 1'b0, injectTck = 1'b0, upstreamParentActive = 1'b0, condScanIn = 1'b0;
  logic condScanOut, clkOut, condScanOutP, clkOutP;

  int nChecks = 0, nFails = 0;
  int nOut = 0, nOutP = 0, nFast = 0, nSlow = 0, nTck = 0;
  bit done = 1'b0;

  // 250 MHz fast clock; slow and tck edges on odd ns, fast on even ns
  always #2 fastClk = ~fastClk;
  initial begin #1; forever #20 slowClk = ~slowClk; end
  initial begin #1; forever #6 tckClk = ~tckClk; end

  always @(posedge clkOut)  nOut++;
  always @(posedge clkOutP) nOutP++;
  always @(posedge fastClk) nFast++;
  always @(posedge slowClk) nSlow++;
  always @(posedge tckClk)  nTck++;

  scanClockCtl #(.COND_LEN(COND_LEN), .PARENT_MODE(1'b0)) u0 (
    .fastClk(fastClk), .slowClk(slowClk), .tckClk(tckClk), .rstN(rstN),
    .testMode(testMode), .scanEn(scanEn), .fastCaptureMode(fastCaptureMode),
    .shiftOnlyMode(shiftOnlyMode), .killClockEn(killClockEn), .injectTck(injectTck),
    .upstreamParentActive(upstreamParentActive), .condScanIn(condScanIn),
    .condScanOut(condScanOut), .clkOut(clkOut));

  scanClockCtl #(.COND_LEN(COND_LEN), .PARENT_MODE(1'b1)) u1 (
    .fastClk(fastClk), .slowClk(slowClk), .tckClk(tckClk), .rstN(rstN),
    .testMode(testMode), .scanEn(scanEn), .fastCaptureMode(fastCaptureMode),
    .shiftOnlyMode(shiftOnlyMode), .killClockEn(killClockEn), .injectTck(injectTck),
    .upstreamParentActive(upstreamParentActive), .condScanIn(condScanIn),
    .condScanOut(condScanOutP), .clkOut(clkOutP));

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 none, 1 fast, 2 slow, 3 tck; idle controller only
  function automatic int idleSource(bit kill, bit shOnly, bit se, bit inj);
    if (inj) return 3;
    if (shOnly && se) return 2;
    if (kill) return 0;
    return 1;
  endfunction

  function automatic int trailingOnes(logic [COND_LEN-1:0] p);
    int n = 0;
    bit run = 1'b1;
    for (int i = 0; i < COND_LEN; i++) begin
      if (run && p[i]) n++;
      else run = 1'b0;
    end
    return n;
  endfunction

  task automatic measureIdle(input int src, input string tag);
    int o0, p0, f0, s0, t0, expN, expP;
    #100;
    o0 = nOut; p0 = nOutP; f0 = nFast; s0 = nSlow; t0 = nTck;
    #400;
    case (src)
      1: expN = nFast - f0;
      2: expN = nSlow - s0;
      3: expN = nTck - t0;
      default: expN = 0;
    endcase
    expP = expN;
    check(tag, nOut - o0, expN);
    check({tag, " R9 parent"}, nOutP - p0, expP);
  endtask

  task automatic setIdle(input bit kill, input bit shOnly, input bit se, input bit inj);
    @(negedge slowClk); #0.5;
    testMode = 1'b0; killClockEn = kill; shiftOnlyMode = shOnly; scanEn = se; injectTck = inj;
  endtask

  task automatic capture(input logic [COND_LEN-1:0] p, input bit fcm, input bit up, input bit kill);
    int o0, s0, f0, p0, trail;
    trail = trailingOnes(p);
    @(negedge slowClk); #0.5;
    testMode = 1'b1; scanEn = 1'b1; injectTck = 1'b0; shiftOnlyMode = 1'b0;
    fastCaptureMode = fcm; upstreamParentActive = up; killClockEn = kill;
    @(negedge slowClk); #0.5;
    o0 = nOut; s0 = nSlow;
    for (int i = 0; i < COND_LEN; i++) begin
      condScanIn = p[i];
      @(negedge slowClk); #0.5;
    end
    condScanIn = 1'b0;
    check("R3 shift edges", nOut - o0, nSlow - s0);
    check("R3 cond out after load", int'(condScanOut), int'(p[0]));
    o0 = nOut;
    scanEn = 1'b0;
    if (fcm) begin
      @(posedge fastClk); @(posedge fastClk); #1.5;
      check("R6 early pulses", nOut - o0, up ? ((trail < 2) ? trail : 2) : 0);
    end
    #400;
    check(fcm ? "R4 fast pulse count (R2 kill ignored)" : "R5 slow pulse count (R2 kill ignored)",
          nOut - o0, trail);
    o0 = nOut; p0 = nOutP; f0 = nFast; s0 = nSlow;
    #200;
    check(fcm ? "R4 held low" : "R5 held low", nOut - o0, 0);
    check("R9 parent capture clock", nOutP - p0, fcm ? (nFast - f0) : (nSlow - s0));
  endtask

  initial begin
    void'($urandom(32'd7341));
    #50.5;
    rstN = 1'b1;
    #0.5;
    check("R3 reset cond out", int'(condScanOut), 0);

    setIdle(1'b0, 1'b0, 1'b0, 1'b0); measureIdle(1, "R1 function fast");
    setIdle(1'b1, 1'b0, 1'b0, 1'b0); measureIdle(0, "R2 kill");
    setIdle(1'b0, 1'b1, 1'b1, 1'b0); measureIdle(2, "R8 shift-only");
    setIdle(1'b1, 1'b1, 1'b1, 1'b0); measureIdle(2, "R8 shift-only with kill");
    setIdle(1'b0, 1'b0, 1'b0, 1'b1); measureIdle(3, "R7 tck inject");
    setIdle(1'b1, 1'b1, 1'b0, 1'b1); measureIdle(3, "R7 tck inject with kill");

    for (int k = 0; k < 16; k++) begin
      bit kl, so, se, ij;
      kl = 1'($urandom); so = 1'($urandom); se = 1'($urandom); ij = 1'($urandom);
      setIdle(kl, so, se, ij);
      measureIdle(idleSource(kl, so, se, ij), "R1/R2/R7/R8 random idle mode");
    end

    capture('0, 1'b1, 1'b0, 1'b0);
    capture('1, 1'b1, 1'b0, 1'b0);
    capture('1, 1'b1, 1'b1, 1'b0);
    capture(4'b0110, 1'b1, 1'b1, 1'b1);
    capture('1, 1'b0, 1'b0, 1'b1);
    capture(4'b0011, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 24; k++) begin
      capture(COND_LEN'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule